// File: doc/BRIEF.md
# Bidirectional GPIO Port with Address-Masked Data Access

This block is an 8-pin general-purpose parallel port that sits on a simple 32-bit register bus. The bus has an address, a write strobe, write data and read data. Each pin has its own direction bit. A pin set to output drives the value held in an output latch. A pin set to input is sampled through a two-flop synchronizer, and its level is returned to software.

The data register does not sit at a single address. It fills a 1 KB window, and address bits [9:2] of an access form a per-pin mask. A write through any alias of the window updates only the latch bits selected by the mask. A read through an alias returns zero in every bit the mask leaves out. Software can therefore set, clear or sample any subset of pins in a single bus cycle, with no read-modify-write sequence.

The bus is a plain register interface with no valid/ready handshake. A write is taken on the clock edge where the strobe is high. Read data follows the address combinationally. The bus never stalls, so the block has no back-pressure.

Top module: `gpio_port`

## Requirements
- R1: After reset the output latch and the direction register are 0, so every pin is an input, `pin_oe` is 0 and `pin_out` is 0.
- R2: The direction register is read and written at byte offset 0x400 through bits [7:0]. A direction bit of 1 makes its pin an output and 0 makes it an input, chosen independently per pin. `pin_oe` equals the direction register, and a write is visible on `pin_oe` one cycle after the write edge.
- R3: The data window covers offsets 0x000 to 0x3FC, and offset bit 2+b is the mask bit for pin b. A write updates latch bit b from `bus_wdata[b]` only where the mask bit is 1; all other latch bits keep their value. The latch drives `pin_out`.
- R4: A data read returns 0 in every bit position whose mask bit is 0. A mask of 0 (offset 0x000) reads all zeros and writes nothing.
- R5: In a data read, a masked bit returns the latch value for an output pin and the synchronized pin level for an input pin.
- R6: A change on `pin_in` appears in data reads after exactly two rising clock edges.
- R7: `bus_rdata[31:8]` is always 0, whatever the address and whatever the upper write data.
- R8: Writing to bits whose pins are inputs leaves those pins undriven (`pin_oe` stays 0) and leaves their read value equal to the external pin level.
- R9: Addresses outside the data window and the direction register read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Output latch, driven onto pins |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
On every cycle the assertions check four things: the masked-write rule (selected latch bits load, the others hold), zeros in the unmasked positions of data reads, direction writes reaching `pin_oe` one cycle later, and the two-edge synchronizer delay. Some behaviours can only be shown by the bench's scenarios: how output and input pins combine in one read, writes to input pins leaving the pins untouched, and accesses to unmapped offsets. Each of these needs a chosen mix of direction, pin levels and aliases, checked against values worked out by hand.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W    = 8;
  localparam int ADDR_W    = 12;
  localparam int BUS_W     = 32;
  localparam int MASK_LSB  = 2;
  localparam int DIR_BYTE  = 'h400;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[k] <= '0;
          else        stage_q[k] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[k] <= '0;
          else        stage_q[k] <= stage_q[k-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];

  // Latency check: enabled once enough edges have passed since reset.
  localparam int AGE_W = $clog2(STAGES + 2);
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                          age_q <= '0;
    else if (age_q != AGE_W'(STAGES + 1)) age_q <= age_q + 1'b1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      a_r6_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == AGE_W'(STAGES + 1)) |-> (q_out == $past(d_in, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (data_we) begin
      latch_q <= (latch_q & ~mask) | (wdata & mask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= wdata;
  end

  a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(data_we) |-> ((latch_q & ~$past(mask)) == ($past(latch_q) & ~$past(mask))));

  a_r3_masked_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(data_we) |-> ((latch_q & $past(mask)) == ($past(wdata) & $past(mask))));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_we) |-> $stable(latch_q));
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux #(
  parameter int W     = 8,
  parameter int BUS_W = 32
) (
  input  logic             sel_data,
  input  logic             sel_dir,
  input  logic [W-1:0]     mask,
  input  logic [W-1:0]     latch_q,
  input  logic [W-1:0]     dir_q,
  input  logic [W-1:0]     pin_sync,
  output logic [BUS_W-1:0] rdata
);
  logic [W-1:0] level;

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign level[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (sel_data)     rdata[W-1:0] = level & mask;
    else if (sel_dir) rdata[W-1:0] = dir_q;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  localparam int WIN_MSB  = MASK_LSB + PORT_W;
  localparam int DIR_WORD = DIR_BYTE >> MASK_LSB;

  logic              sel_data, sel_dir;
  logic [PORT_W-1:0] mask, latch_q, dir_q, pin_sync;

  assign sel_data = (bus_addr[ADDR_W-1:WIN_MSB] == '0);
  assign sel_dir  = (bus_addr[ADDR_W-1:MASK_LSB] == (ADDR_W-MASK_LSB)'(DIR_WORD));
  assign mask     = bus_addr[WIN_MSB-1:MASK_LSB];

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(pin_sync));

  gpio_regs #(.W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .data_we(bus_we && sel_data), .dir_we(bus_we && sel_dir),
    .mask(mask), .wdata(bus_wdata[PORT_W-1:0]),
    .latch_q(latch_q), .dir_q(dir_q));

  gpio_rdmux #(.W(PORT_W), .BUS_W(BUS_W)) u_rd (
    .sel_data(sel_data), .sel_dir(sel_dir), .mask(mask),
    .latch_q(latch_q), .dir_q(dir_q), .pin_sync(pin_sync),
    .rdata(bus_rdata));

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;

  a_r4_unmasked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel_data |-> ((bus_rdata[PORT_W-1:0] & ~bus_addr[WIN_MSB-1:MASK_LSB]) == '0));

  a_r2_dir_write_reaches_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && sel_dir) |-> (pin_oe == $past(bus_wdata[PORT_W-1:0])));

  a_r2_oe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we && sel_dir) |-> $stable(pin_oe));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_port u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  // {write, waddr, wdata, raddr, expected}
  typedef struct packed {
    logic        we;
    logic [11:0] waddr;
    logic [7:0]  wdata;
    logic [11:0] raddr;
    logic [7:0]  exp;
  } vec_t;

  // Setup: direction 0x0F, pins 0xA5, latch 0.
  localparam vec_t VECS [10] = '{
    '{1'b1, 12'h3FC, 8'hFF, 12'h3FC, 8'hAF},
    '{1'b1, 12'h004, 8'h00, 12'h3FC, 8'hAE},
    '{1'b1, 12'h018, 8'hFF, 12'h018, 8'h06},
    '{1'b1, 12'h030, 8'h04, 12'h03C, 8'h06},
    '{1'b0, 12'h000, 8'h00, 12'h200, 8'h80},
    '{1'b0, 12'h000, 8'h00, 12'h100, 8'h00},
    '{1'b1, 12'h3C0, 8'h00, 12'h3FC, 8'hA6},
    '{1'b0, 12'h000, 8'h00, 12'h000, 8'h00},
    '{1'b1, 12'h000, 8'hFF, 12'h3FC, 8'hA6},
    '{1'b0, 12'h000, 8'h00, 12'h400, 8'h0F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
    check("R1 pin_out", {24'h0, pin_out}, 32'h0);
    bus_read(12'h400, rd); check("R1 dir reads 0", rd, 32'h0);

    // Setup for the vector table
    pin_in = 8'hA5;
    bus_write(12'h400, 32'hFFFF_FF0F);
    check("R2 oe after dir write", {24'h0, pin_oe}, 32'h0F);
    repeat (3) @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      if (VECS[i].we) bus_write(VECS[i].waddr, {24'hFFFFFF, VECS[i].wdata});
      bus_read(VECS[i].raddr, rd);
      check("R3/R4/R5/R7 vector", rd, {24'h0, VECS[i].exp});
    end

    // R8: bits written while inputs stay undriven, read shows pin level
    check("R8 oe unchanged", {24'h0, pin_oe}, 32'h0F);
    bus_write(12'h3C0, 32'hFFFF_FFFF);
    bus_read(12'h3C0, rd); check("R8 input read is pin", rd, 32'hA0);
    check("R8 oe still low on inputs", {24'h0, pin_oe}, 32'h0F);
    bus_write(12'h3C0, 32'h0);

    // R2: all outputs; read now shows latch
    bus_write(12'h400, 32'hFF);
    check("R2 oe all out", {24'h0, pin_oe}, 32'hFF);
    bus_read(12'h3FC, rd); check("R2 outputs read latch", rd, 32'h06);
    check("R3 pin_out latch", {24'h0, pin_out}, 32'h06);

    // R6: synchronizer latency
    bus_write(12'h400, 32'h00);
    repeat (3) @(negedge clk);
    bus_addr = 12'h3FC;
    pin_in = 8'h3C;
    @(posedge clk); @(negedge clk); #1;
    check("R6 one edge: old value", bus_rdata, 32'hA5);
    @(posedge clk); @(negedge clk); #1;
    check("R6 two edges: new value", bus_rdata, 32'h3C);

    // R7: upper bits on direction read
    bus_write(12'h400, 32'hFFFF_FF81);
    bus_read(12'h400, rd); check("R7 dir upper zero", rd, 32'h81);

    // R9: unmapped offsets
    bus_read(12'h800, rd); check("R9 unmapped read", rd, 32'h0);
    bus_write(12'h800, 32'hFF);
    bus_write(12'h404, 32'hFF);
    check("R9 dir untouched", {24'h0, pin_oe}, 32'h81);
    check("R9 latch untouched", {24'h0, pin_out}, 32'h06);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule